// File: doc/BRIEF.md
# Flag-Conditioned Program Counter

This block holds the fetch address of a byte-serial sequencer. Each advance pulse moves the counter forward by one byte, so every byte of an instruction slot, the execute byte included, takes one address. On an advance, the counter can instead take a new 16-bit value from a jump target presented as two bytes. A load always replaces that cycle's increment, so the next byte is fetched from the target itself.

The choice between counting and loading comes from two active-low condition controls and one flag chosen from four candidates by a 2-bit select. The two controls together encode four cases: no jump, unconditional jump, jump when the flag is clear, and jump when the flag is set. A separate address-source control puts either the counter or an externally held temporary address on the address output. Temporary accesses therefore never disturb the program flow. Every pin is a plain control or data level sampled on the clock, with no handshake.

Top module: `pc_seq_core`

## Requirements
- R1: While `rst_n` is low the counter is 0000h, so `addr` reads 0000h when `use_pc` is high.
- R2: With `step_en` high and no load, the counter rises by one per clock and wraps from FFFFh to 0000h.
- R3: With `step_en` low the counter keeps its value, whatever the condition controls, flags and target are.
- R4: With `cond_clr_n` and `cond_set_n` both high the counter counts, whatever the selected flag is.
- R5: With `cond_clr_n` and `cond_set_n` both low, an advance loads `{tgt_hi, tgt_lo}`, whatever the selected flag is.
- R6: With `cond_clr_n` low and `cond_set_n` high, an advance loads the target when the selected flag is 0 and counts when it is 1.
- R7: With `cond_clr_n` high and `cond_set_n` low, an advance loads the target when the selected flag is 1 and counts when it is 0.
- R8: `flag_sel` picks the tested flag: 0 = `flag_minus`, 1 = `flag_zero`, 2 = `flag_carry_raw`, 3 = `flag_carry_held`.
- R9: `addr` follows the counter in the same cycle when `use_pc` is high, and follows `tmp_addr` when it is low. The counter keeps advancing while `tmp_addr` is shown.
- R10: A load takes the place of the increment. The address after a load equals the target, and the next advance without a load gives target plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Advance enable: count or load on this edge |
| tgt_lo | input | 8 | Jump target, low byte |
| tgt_hi | input | 8 | Jump target, high byte |
| tmp_addr | input | 16 | Temporary address for non-program accesses |
| flag_minus | input | 1 | Result bit 7 flag |
| flag_zero | input | 1 | Whole-byte zero flag |
| flag_carry_raw | input | 1 | Carry straight from the ALU |
| flag_carry_held | input | 1 | Stored carry |
| flag_sel | input | 2 | Tested-flag select (see R8) |
| cond_clr_n | input | 1 | Active-low: jump when the flag is clear |
| cond_set_n | input | 1 | Active-low: jump when the flag is set |
| use_pc | input | 1 | High: counter drives `addr`; low: `tmp_addr` drives it |
| addr | output | 16 | Address output |

## Verification
The assertions check the counter's next-state rule on every clock edge: it holds its value while advance is off, it increments with wrap when both controls are high, and it loads the target in the unconditional case and in both flag-qualified cases, judged from the picked flag. The bench scenarios show what those cycle-level properties cannot see from the ports. These are the mapping from each `flag_sel` code to the right flag input, the same-cycle switch of the address source while the counter keeps running underneath, and the carry-on from a loaded target.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;
  // Position of each candidate flag in the packed flag vector; flag_sel uses this code.
  typedef enum logic [1:0] {
    FSEL_MINUS      = 2'd0,
    FSEL_ZERO       = 2'd1,
    FSEL_CARRY_RAW  = 2'd2,
    FSEL_CARRY_HELD = 2'd3
  } fsel_e;

  localparam int unsigned FLAG_COUNT = 4;

  // Next-state choice of the counter.
  typedef enum logic [1:0] {
    PC_HOLD = 2'd0,
    PC_INC  = 2'd1,
    PC_LOAD = 2'd2
  } pc_op_e;
endpackage

// File: rtl/pc_flag_pick.sv
module pc_flag_pick #(
  parameter int unsigned N_FLAGS = 4,
  localparam int unsigned SEL_W = (N_FLAGS > 1) ? $clog2(N_FLAGS) : 1
) (
  input  logic [N_FLAGS-1:0] flags,
  input  logic [SEL_W-1:0]   sel,
  output logic               picked
);
  logic [N_FLAGS-1:0] hit;

  // One AND term per candidate; the OR of all terms is the picked flag.
  for (genvar g = 0; g < N_FLAGS; g++) begin : g_term
    assign hit[g] = (sel == SEL_W'(g)) & flags[g];
  end

  assign picked = |hit;
endmodule

// File: rtl/pc_branch_decide.sv
module pc_branch_decide (
  input  logic step_en,
  input  logic cond_clr_n,
  input  logic cond_set_n,
  input  logic flag,
  output pc_seq_pkg::pc_op_e op
);
  import pc_seq_pkg::*;

  logic take;

  // A low control arms its half: the clear half fires on flag 0, the set half on flag 1.
  // Both low arms both halves, so one of them always fires.
  always_comb begin
    take = ((~cond_clr_n) & (~flag)) | ((~cond_set_n) & flag);
    if (!step_en)  op = PC_HOLD;
    else if (take) op = PC_LOAD;
    else           op = PC_INC;
  end
endmodule

// File: rtl/pc_count_reg.sv
module pc_count_reg #(
  parameter int unsigned W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  pc_seq_pkg::pc_op_e op,
  input  logic [W-1:0]       target,
  output logic [W-1:0]       pc
);
  import pc_seq_pkg::*;

  logic [W-1:0] pc_nxt;

  always_comb begin
    unique case (op)
      PC_INC:  pc_nxt = pc + W'(1);
      PC_LOAD: pc_nxt = target;
      default: pc_nxt = pc;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= '0;
    else        pc <= pc_nxt;
  end
endmodule

// File: rtl/pc_addr_mux.sv
module pc_addr_mux #(
  parameter int unsigned W = 16
) (
  input  logic         use_pc,
  input  logic [W-1:0] pc,
  input  logic [W-1:0] tmp,
  output logic [W-1:0] addr
);
  always_comb addr = use_pc ? pc : tmp;
endmodule

// File: rtl/pc_seq_core.sv
module pc_seq_core #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned ADDR_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic [BYTE_W-1:0] tgt_lo,
  input  logic [BYTE_W-1:0] tgt_hi,
  input  logic [ADDR_W-1:0] tmp_addr,
  input  logic              flag_minus,
  input  logic              flag_zero,
  input  logic              flag_carry_raw,
  input  logic              flag_carry_held,
  input  logic [1:0]        flag_sel,
  input  logic              cond_clr_n,
  input  logic              cond_set_n,
  input  logic              use_pc,
  output logic [ADDR_W-1:0] addr
);
  import pc_seq_pkg::*;

  logic [FLAG_COUNT-1:0] flag_vec;
  logic                  flag_pick;
  pc_op_e                pc_op;
  logic [ADDR_W-1:0]     target;
  logic [ADDR_W-1:0]     pc_val;

  always_comb begin
    flag_vec                  = '0;
    flag_vec[FSEL_MINUS]      = flag_minus;
    flag_vec[FSEL_ZERO]       = flag_zero;
    flag_vec[FSEL_CARRY_RAW]  = flag_carry_raw;
    flag_vec[FSEL_CARRY_HELD] = flag_carry_held;
  end

  // Both target bytes are taken together, so a load moves all address bits at once.
  assign target = {tgt_hi, tgt_lo};

  pc_flag_pick #(.N_FLAGS(FLAG_COUNT)) u_pick (
    .flags  (flag_vec),
    .sel    (flag_sel),
    .picked (flag_pick)
  );

  pc_branch_decide u_decide (
    .step_en    (step_en),
    .cond_clr_n (cond_clr_n),
    .cond_set_n (cond_set_n),
    .flag       (flag_pick),
    .op         (pc_op)
  );

  pc_count_reg #(.W(ADDR_W)) u_pc (
    .clk    (clk),
    .rst_n  (rst_n),
    .op     (pc_op),
    .target (target),
    .pc     (pc_val)
  );

  pc_addr_mux #(.W(ADDR_W)) u_mux (
    .use_pc (use_pc),
    .pc     (pc_val),
    .tmp    (tmp_addr),
    .addr   (addr)
  );
endmodule

// File: rtl/pc_seq_core_chk.sv
module pc_seq_core_chk #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned ADDR_W = 2 * BYTE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              step_en,
  input logic              cond_clr_n,
  input logic              cond_set_n,
  input logic [BYTE_W-1:0] tgt_lo,
  input logic [BYTE_W-1:0] tgt_hi,
  input logic              flag_pick,
  input logic [ADDR_W-1:0] pc_val
);
  // R1
  reset_zero_chk: assert property (@(posedge clk) !rst_n |-> pc_val == '0);

  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(pc_val));

  // R4
  count_when_armed_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && cond_clr_n && cond_set_n) |=> pc_val == $past(pc_val) + ADDR_W'(1));

  // R5
  always_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !cond_clr_n && !cond_set_n) |=> pc_val == $past({tgt_hi, tgt_lo}));

  // R6
  jump_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !cond_clr_n && cond_set_n) |=>
      pc_val == ($past(flag_pick) ? $past(pc_val) + ADDR_W'(1) : $past({tgt_hi, tgt_lo})));

  // R7
  jump_on_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && cond_clr_n && !cond_set_n) |=>
      pc_val == ($past(flag_pick) ? $past({tgt_hi, tgt_lo}) : $past(pc_val) + ADDR_W'(1)));
endmodule

bind pc_seq_core pc_seq_core_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .step_en    (step_en),
  .cond_clr_n (cond_clr_n),
  .cond_set_n (cond_set_n),
  .tgt_lo     (tgt_lo),
  .tgt_hi     (tgt_hi),
  .flag_pick  (flag_pick),
  .pc_val     (pc_val)
);

// File: tb/pc_seq_core_test.sv
module pc_seq_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_en = 1'b0;
  logic [7:0]  tgt_lo = '0;
  logic [7:0]  tgt_hi = '0;
  logic [15:0] tmp_addr = '0;
  logic        flag_minus = 1'b0;
  logic        flag_zero = 1'b0;
  logic        flag_carry_raw = 1'b0;
  logic        flag_carry_held = 1'b0;
  logic [1:0]  flag_sel = '0;
  logic        cond_clr_n = 1'b1;
  logic        cond_set_n = 1'b1;
  logic        use_pc = 1'b1;
  logic [15:0] addr;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pc_seq_core uut (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .tgt_lo(tgt_lo), .tgt_hi(tgt_hi),
    .tmp_addr(tmp_addr), .flag_minus(flag_minus), .flag_zero(flag_zero),
    .flag_carry_raw(flag_carry_raw), .flag_carry_held(flag_carry_held),
    .flag_sel(flag_sel), .cond_clr_n(cond_clr_n), .cond_set_n(cond_set_n),
    .use_pc(use_pc), .addr(addr)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: addr=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock; inputs change and outputs are sampled 1 ns after the rising edge.
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic set_target(input logic [15:0] v);
    tgt_hi = v[15:8];
    tgt_lo = v[7:0];
  endtask

  task automatic jump_to(input logic [15:0] v);
    use_pc = 1'b1; step_en = 1'b1;
    set_target(v);
    cond_clr_n = 1'b0; cond_set_n = 1'b0;
    tick();
    cond_clr_n = 1'b1; cond_set_n = 1'b1;
    step_en = 1'b0;
  endtask

  // Drive every flag to the opposite of fval except the selected one (R8).
  task automatic set_flags(input logic [1:0] sel, input logic fval);
    flag_sel = sel;
    flag_minus      = (sel == 2'd0) ? fval : ~fval;
    flag_zero       = (sel == 2'd1) ? fval : ~fval;
    flag_carry_raw  = (sel == 2'd2) ? fval : ~fval;
    flag_carry_held = (sel == 2'd3) ? fval : ~fval;
  endtask

  task automatic t_reset();
    #1;
    check("R1 reset", addr, 16'h0000);
    tick();
    check("R1 reset held", addr, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic t_count();
    step_en = 1'b1;
    for (int i = 1; i <= 5; i++) begin
      tick();
      check("R2 count", addr, 16'(i));
    end
    step_en = 1'b0;
  endtask

  task automatic t_wrap();
    jump_to(16'hFFFE);
    step_en = 1'b1;
    tick();
    check("R2 to top", addr, 16'hFFFF);
    tick();
    check("R2 wrap", addr, 16'h0000);
    step_en = 1'b0;
  endtask

  task automatic t_hold();
    jump_to(16'h4321);
    step_en = 1'b0;
    set_target(16'h9999);
    cond_clr_n = 1'b0; cond_set_n = 1'b0;
    for (int i = 0; i < 3; i++) tick();
    check("R3 hold no load", addr, 16'h4321);
    cond_clr_n = 1'b1; cond_set_n = 1'b1;
    tick();
    check("R3 hold no count", addr, 16'h4321);
  endtask

  task automatic t_never();
    for (int f = 0; f < 2; f++) begin
      jump_to(16'h2000);
      set_target(16'h7777);
      set_flags(2'd1, f[0]);
      step_en = 1'b1;
      tick();
      check("R4 never jump", addr, 16'h2001);
      step_en = 1'b0;
    end
  endtask

  task automatic t_always();
    for (int f = 0; f < 2; f++) begin
      jump_to(16'h3000);
      set_target(16'hBEEF);
      set_flags(2'd2, f[0]);
      cond_clr_n = 1'b0; cond_set_n = 1'b0;
      step_en = 1'b1;
      tick();
      check("R5 always jump", addr, 16'hBEEF);
      cond_clr_n = 1'b1; cond_set_n = 1'b1;
      step_en = 1'b0;
    end
  endtask

  // mode 0: jump when clear (R6); mode 1: jump when set (R7); every select code (R8).
  task automatic t_conditional(input int mode);
    for (int s = 0; s < 4; s++) begin
      for (int f = 0; f < 2; f++) begin
        logic jump;
        jump_to(16'h1000 + 16'(s * 16));
        set_target(16'hC000 + 16'(s));
        set_flags(2'(s), f[0]);
        cond_clr_n = (mode == 0) ? 1'b0 : 1'b1;
        cond_set_n = (mode == 0) ? 1'b1 : 1'b0;
        step_en = 1'b1;
        tick();
        jump = (mode == 0) ? (f == 0) : (f == 1);
        check((mode == 0) ? "R6/R8 jump if clear" : "R7/R8 jump if set", addr,
              jump ? 16'hC000 + 16'(s) : 16'h1001 + 16'(s * 16));
        cond_clr_n = 1'b1; cond_set_n = 1'b1;
        step_en = 1'b0;
      end
    end
  endtask

  task automatic t_addr_mux();
    jump_to(16'h5000);
    tmp_addr = 16'hA5A5;
    use_pc = 1'b0;
    #1;
    check("R9 temp shown", addr, 16'hA5A5);
    step_en = 1'b1;
    tick(); tick(); tick();
    check("R9 temp during count", addr, 16'hA5A5);
    step_en = 1'b0;
    use_pc = 1'b1;
    #1;
    check("R9 counter back", addr, 16'h5003);
  endtask

  task automatic t_load_continue();
    jump_to(16'h0100);
    set_target(16'h8040);
    set_flags(2'd3, 1'b1);
    cond_set_n = 1'b0;
    step_en = 1'b1;
    tick();
    check("R10 load replaces inc", addr, 16'h8040);
    cond_set_n = 1'b1;
    tick();
    check("R10 resume from target", addr, 16'h8041);
    step_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    total++;
    bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    t_reset();
    t_count();
    t_wrap();
    t_hold();
    t_never();
    t_always();
    t_conditional(0);
    t_conditional(1);
    t_addr_mux();
    t_load_continue();
    finish_run();
  end
endmodule